// File: doc/BRIEF.md
# Digital Video Raster Timing Generator

This block builds the complete line and frame timing for a digital video output running from the pixel clock. Two counters run through a programmable raster: the number of clocks per line, the blanking clocks at the start of each line, the number of lines per frame, and the active-line window of each of two fields. From their position the block produces one 8/10-bit multiplexed stream. Each line opens with an end-of-active-video code and blanking fill. A start-of-active-video code follows, and then the co-sited 4:2:2 samples in the order Cb, Y, Cr, Y.

Samples come from an upstream buffer. The buffer must present its next sample on `pix_in` in the same clock that `pix_req` is high. The block then clips the sample to separate luma and chroma limits. Code words and blanking fill are never clipped. The block also drives horizontal sync, vertical sync, a composite blanking flag, the field flag and a one-clock frame pulse. All of these are aligned with the data word they belong to.

Top module: `raster_gen_656`

## Requirements
- R1: While `rst_n` is low, `vd_out` is 0, every sync, flag and pulse output is 0, and `pix_req` is 0.
- R2: The horizontal position counts 0 to `cfg_line_len`-1 and the line counts 0 to `cfg_frame_lines`-1. `fsync_o` is high for exactly the one word at line position 0 of line 0.
- R3: Line positions 0..3 carry the end code 3FFh, 000h, 000h, status word, where the status word has H=1.
- R4: Positions `cfg_hblank`-4 .. `cfg_hblank`-1 carry the start code 3FFh, 000h, 000h, status word, where the status word has H=0. This needs `cfg_hblank` of at least 8.
- R5: The 8-bit status word is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. It is shifted left by `DW`-8 bits on the output.
- R6: F is 1 on lines at or above `cfg_f2_line` and 0 otherwise, and `field_o` shows F. V is 0 only on lines in [`cfg_a1_start`,`cfg_a1_end`) or [`cfg_a2_start`,`cfg_a2_end`).
- R7: Blanking fill is 200h for chroma and 040h for luma (80h and 10h in 8-bit terms). In horizontal blanking, even positions carry chroma. In the active part of a line with V=1, even offsets from `cfg_hblank` carry chroma.
- R8: `pix_req` is high exactly on positions at or above `cfg_hblank` on lines with V=0. The sample taken from `pix_in` appears on `vd_out` one clock later.
- R9: Active luma samples (odd offsets from `cfg_hblank`) are clipped to [`cfg_y_min`, `cfg_y_max`].
- R10: Active chroma samples (even offsets) are clipped to [`cfg_c_min`, `cfg_c_max`]. Code words and fill are never clipped.
- R11: `hsync_o` is high on line positions below `cfg_hsync_len`.
- R12: `vsync_o` is high on lines below `cfg_vsync_lines`, and on lines from `cfg_f2_line` up to but not including `cfg_f2_line`+`cfg_vsync_lines`.
- R13: `blank_o` is high when the position is below `cfg_hblank` or when V=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_line_len | input | HW | Clocks per line |
| cfg_hblank | input | HW | Blanking clocks at line start, codes included |
| cfg_hsync_len | input | HW | Horizontal sync width in clocks |
| cfg_frame_lines | input | VW | Lines per frame |
| cfg_a1_start | input | VW | First active line of field 1 |
| cfg_a1_end | input | VW | Line after the last active line of field 1 |
| cfg_f2_line | input | VW | First line of field 2 |
| cfg_a2_start | input | VW | First active line of field 2 |
| cfg_a2_end | input | VW | Line after the last active line of field 2 |
| cfg_vsync_lines | input | VW | Vertical sync height in lines |
| cfg_y_min | input | DW | Luma lower clip limit |
| cfg_y_max | input | DW | Luma upper clip limit |
| cfg_c_min | input | DW | Chroma lower clip limit |
| cfg_c_max | input | DW | Chroma upper clip limit |
| pix_in | input | DW | Sample from the buffer, valid while pix_req is high |
| pix_req | output | 1 | Sample fetch strobe |
| vd_out | output | DW | Multiplexed video word |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Composite blanking |
| field_o | output | 1 | Field flag |
| fsync_o | output | 1 | Frame pulse |

## Verification
`pix_req` is decoded from the counters without a register. The bench therefore checks it against its own raster position in the same cycle, before the edge. Every other output is registered once, so the result for a given raster position is due one clock later. The driver computes the expected word and flags for that position from the requirements and queues them at the falling edge. The monitor pops them one time unit after the next rising edge and compares, so each check lands in the cycle the register has just loaded.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [2:0] {
    SEG_EAV,
    SEG_HFILL,
    SEG_SAV,
    SEG_VFILL,
    SEG_PIX
  } seg_e;

  localparam int unsigned CODE_LEN = 4;
endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [VW-1:0] cfg_frame_lines,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);
  logic [HW-1:0] hcnt_d;
  logic [VW-1:0] vcnt_d;
  logic          h_last;
  logic          v_last;

  always_comb begin
    h_last = (hcnt == cfg_line_len - HW'(1));
    v_last = (vcnt == cfg_frame_lines - VW'(1));
    hcnt_d = h_last ? '0 : hcnt + HW'(1);
    vcnt_d = vcnt;
    if (h_last) vcnt_d = v_last ? '0 : vcnt + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end

  a_r2_hcnt_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < cfg_line_len);
endmodule

// File: rtl/raster_field_decode.sv
module raster_field_decode #(
  parameter int unsigned VW = 11
) (
  input  logic [VW-1:0] vcnt,
  input  logic [VW-1:0] cfg_a1_start,
  input  logic [VW-1:0] cfg_a1_end,
  input  logic [VW-1:0] cfg_f2_line,
  input  logic [VW-1:0] cfg_a2_start,
  input  logic [VW-1:0] cfg_a2_end,
  input  logic [VW-1:0] cfg_vsync_lines,
  output logic          f_bit,
  output logic          v_bit,
  output logic          vsync
);
  logic in_act1;
  logic in_act2;
  logic [VW:0] vs2_end;

  always_comb begin
    in_act1 = (vcnt >= cfg_a1_start) && (vcnt < cfg_a1_end);
    in_act2 = (vcnt >= cfg_a2_start) && (vcnt < cfg_a2_end);
    f_bit   = (vcnt >= cfg_f2_line);
    v_bit   = !(in_act1 || in_act2);
    vs2_end = {1'b0, cfg_f2_line} + {1'b0, cfg_vsync_lines};
    vsync   = (vcnt < cfg_vsync_lines) ||
              (f_bit && ({1'b0, vcnt} < vs2_end));
  end
endmodule

// File: rtl/raster_word_gen.sv
module raster_word_gen
  import raster_pkg::*;
#(
  parameter int unsigned DW = 10,
  parameter int unsigned HW = 12
) (
  input  logic [HW-1:0] hcnt,
  input  logic [HW-1:0] cfg_hblank,
  input  logic          f_bit,
  input  logic          v_bit,
  input  logic [DW-1:0] cfg_y_min,
  input  logic [DW-1:0] cfg_y_max,
  input  logic [DW-1:0] cfg_c_min,
  input  logic [DW-1:0] cfg_c_max,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] word,
  output logic          req
);
  localparam int unsigned SH = DW - 8;
  localparam logic [DW-1:0] FILL_C = DW'(8'h80) << SH;
  localparam logic [DW-1:0] FILL_Y = DW'(8'h10) << SH;

  seg_e          seg;
  logic [HW-1:0] sav_base;
  logic [HW-1:0] code_idx;
  logic [HW-1:0] act_off;

  function automatic logic [DW-1:0] status_word(input logic f, input logic v, input logic h);
    logic [7:0] b;
    b = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return DW'(b) << SH;
  endfunction

  function automatic logic [DW-1:0] clamp(input logic [DW-1:0] x,
                                          input logic [DW-1:0] lo,
                                          input logic [DW-1:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  function automatic logic [DW-1:0] code_word(input logic [1:0] idx, input logic [DW-1:0] st);
    case (idx)
      2'd0:    return '1;
      2'd3:    return st;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    sav_base = cfg_hblank - HW'(CODE_LEN);
    act_off  = hcnt - cfg_hblank;
    code_idx = hcnt;
    if (hcnt < HW'(CODE_LEN))  seg = SEG_EAV;
    else if (hcnt < sav_base)  seg = SEG_HFILL;
    else if (hcnt < cfg_hblank) begin
      seg      = SEG_SAV;
      code_idx = hcnt - sav_base;
    end
    else if (v_bit)            seg = SEG_VFILL;
    else                       seg = SEG_PIX;

    req = 1'b0;
    case (seg)
      SEG_EAV:   word = code_word(code_idx[1:0], status_word(f_bit, v_bit, 1'b1));
      SEG_SAV:   word = code_word(code_idx[1:0], status_word(f_bit, v_bit, 1'b0));
      SEG_HFILL: word = hcnt[0] ? FILL_Y : FILL_C;
      SEG_VFILL: word = act_off[0] ? FILL_Y : FILL_C;
      default: begin
        req  = 1'b1;
        word = act_off[0] ? clamp(pix_in, cfg_y_min, cfg_y_max)
                          : clamp(pix_in, cfg_c_min, cfg_c_max);
      end
    endcase
  end
endmodule

// File: rtl/raster_gen_656.sv
module raster_gen_656 #(
  parameter int unsigned DW = 10,
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_line_len,
  input  logic [HW-1:0] cfg_hblank,
  input  logic [HW-1:0] cfg_hsync_len,
  input  logic [VW-1:0] cfg_frame_lines,
  input  logic [VW-1:0] cfg_a1_start,
  input  logic [VW-1:0] cfg_a1_end,
  input  logic [VW-1:0] cfg_f2_line,
  input  logic [VW-1:0] cfg_a2_start,
  input  logic [VW-1:0] cfg_a2_end,
  input  logic [VW-1:0] cfg_vsync_lines,
  input  logic [DW-1:0] cfg_y_min,
  input  logic [DW-1:0] cfg_y_max,
  input  logic [DW-1:0] cfg_c_min,
  input  logic [DW-1:0] cfg_c_max,
  input  logic [DW-1:0] pix_in,
  output logic          pix_req,
  output logic [DW-1:0] vd_out,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          blank_o,
  output logic          field_o,
  output logic          fsync_o
);
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          f_bit;
  logic          v_bit;
  logic          vsync_d;
  logic [DW-1:0] word_d;
  logic          hsync_d;
  logic          blank_d;
  logic          fsync_d;

  raster_counters #(.HW(HW), .VW(VW)) i_cnt (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_line_len    (cfg_line_len),
    .cfg_frame_lines (cfg_frame_lines),
    .hcnt            (hcnt),
    .vcnt            (vcnt)
  );

  raster_field_decode #(.VW(VW)) i_fld (
    .vcnt            (vcnt),
    .cfg_a1_start    (cfg_a1_start),
    .cfg_a1_end      (cfg_a1_end),
    .cfg_f2_line     (cfg_f2_line),
    .cfg_a2_start    (cfg_a2_start),
    .cfg_a2_end      (cfg_a2_end),
    .cfg_vsync_lines (cfg_vsync_lines),
    .f_bit           (f_bit),
    .v_bit           (v_bit),
    .vsync           (vsync_d)
  );

  raster_word_gen #(.DW(DW), .HW(HW)) i_word (
    .hcnt       (hcnt),
    .cfg_hblank (cfg_hblank),
    .f_bit      (f_bit),
    .v_bit      (v_bit),
    .cfg_y_min  (cfg_y_min),
    .cfg_y_max  (cfg_y_max),
    .cfg_c_min  (cfg_c_min),
    .cfg_c_max  (cfg_c_max),
    .pix_in     (pix_in),
    .word       (word_d),
    .req        (pix_req)
  );

  always_comb begin
    hsync_d = (hcnt < cfg_hsync_len);
    blank_d = (hcnt < cfg_hblank) || v_bit;
    fsync_d = (hcnt == '0) && (vcnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_out  <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      blank_o <= 1'b0;
      field_o <= 1'b0;
      fsync_o <= 1'b0;
    end else begin
      vd_out  <= word_d;
      hsync_o <= hsync_d;
      vsync_o <= vsync_d;
      blank_o <= blank_d;
      field_o <= f_bit;
      fsync_o <= fsync_d;
    end
  end

  a_r8_req_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> !blank_o);
  a_r2_fsync_single: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |=> !fsync_o);
  a_r2_fsync_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> (vd_out == '1));
  a_r6_field_eav_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_o) |-> (vd_out == '1));
endmodule

// File: tb/test_raster_gen_656.sv
module test_raster_gen_656;
  localparam int DW = 10;
  localparam int HW = 12;
  localparam int VW = 11;

  typedef struct {
    logic [DW-1:0] vd;
    logic hs, vs, bl, fd, fs;
    int   tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] cfg_line_len, cfg_hblank, cfg_hsync_len;
  logic [VW-1:0] cfg_frame_lines, cfg_a1_start, cfg_a1_end, cfg_f2_line;
  logic [VW-1:0] cfg_a2_start, cfg_a2_end, cfg_vsync_lines;
  logic [DW-1:0] cfg_y_min, cfg_y_max, cfg_c_min, cfg_c_max, pix_in;
  logic pix_req, hsync_o, vsync_o, blank_o, field_o, fsync_o;
  logic [DW-1:0] vd_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  raster_gen_656 #(.DW(DW), .HW(HW), .VW(VW)) i_raster_gen_656 (
    .clk(clk), .rst_n(rst_n),
    .cfg_line_len(cfg_line_len), .cfg_hblank(cfg_hblank), .cfg_hsync_len(cfg_hsync_len),
    .cfg_frame_lines(cfg_frame_lines), .cfg_a1_start(cfg_a1_start), .cfg_a1_end(cfg_a1_end),
    .cfg_f2_line(cfg_f2_line), .cfg_a2_start(cfg_a2_start), .cfg_a2_end(cfg_a2_end),
    .cfg_vsync_lines(cfg_vsync_lines),
    .cfg_y_min(cfg_y_min), .cfg_y_max(cfg_y_max), .cfg_c_min(cfg_c_min), .cfg_c_max(cfg_c_max),
    .pix_in(pix_in), .pix_req(pix_req), .vd_out(vd_out),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
    .field_o(field_o), .fsync_o(fsync_o)
  );

  function automatic string rname(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check(int t, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rname(t), act, exp_v);
    end
  endtask

  function automatic logic [DW-1:0] stat(logic f, logic v, logic h);
    logic [7:0] b;
    b = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return {b, 2'b00};
  endfunction

  function automatic logic [DW-1:0] lim(logic [DW-1:0] x, logic [DW-1:0] lo, logic [DW-1:0] hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  function automatic bit vbit(int v);
    return !((v >= int'(cfg_a1_start) && v < int'(cfg_a1_end)) ||
             (v >= int'(cfg_a2_start) && v < int'(cfg_a2_end)));
  endfunction

  function automatic exp_t model(int h, int v, logic [DW-1:0] p);
    exp_t e;
    int hb = int'(cfg_hblank);
    logic fb = (v >= int'(cfg_f2_line));
    logic vb = vbit(v);
    e.fs = (h == 0 && v == 0);
    e.hs = (h < int'(cfg_hsync_len));
    e.vs = (v < int'(cfg_vsync_lines)) ||
           (v >= int'(cfg_f2_line) && v < int'(cfg_f2_line) + int'(cfg_vsync_lines));
    e.bl = (h < hb) || vb;
    e.fd = fb;
    if (h < 4) begin
      e.vd  = (h == 0) ? 10'h3FF : (h == 3) ? stat(fb, vb, 1'b1) : 10'h000;
      e.tag = (h == 3) ? 5 : 3;
    end else if (h >= hb - 4 && h < hb) begin
      e.vd  = (h == hb - 4) ? 10'h3FF : (h == hb - 1) ? stat(fb, vb, 1'b0) : 10'h000;
      e.tag = (h == hb - 1) ? 5 : 4;
    end else if (h < hb) begin
      e.vd = (h % 2 == 0) ? 10'h200 : 10'h040;
      e.tag = 7;
    end else if (vb) begin
      e.vd = ((h - hb) % 2 == 0) ? 10'h200 : 10'h040;
      e.tag = 7;
    end else if ((h - hb) % 2 == 0) begin
      e.vd = lim(p, cfg_c_min, cfg_c_max);
      e.tag = 10;
    end else begin
      e.vd = lim(p, cfg_y_min, cfg_y_max);
      e.tag = 9;
    end
    return e;
  endfunction

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, 32'(vd_out), 32'(e.vd));
      check(11, 32'(hsync_o), 32'(e.hs));
      check(12, 32'(vsync_o), 32'(e.vs));
      check(13, 32'(blank_o), 32'(e.bl));
      check(6, 32'(field_o), 32'(e.fd));
      check(2, 32'(fsync_o), 32'(e.fs));
    end
  end

  task automatic run_cfg(int frames, int seed);
    int h = 0;
    int v = 0;
    int k = seed;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 32'(vd_out), 0);
    check(1, 32'({hsync_o, vsync_o, blank_o, field_o, fsync_o}), 0);
    check(1, 32'(pix_req), 0);
    rst_n = 1'b1;
    for (int n = 0; n < frames * int'(cfg_line_len) * int'(cfg_frame_lines); n++) begin
      logic [DW-1:0] p;
      k++;
      p = (k % 5 == 0) ? 10'h000 : (k % 5 == 1) ? 10'h3FF : DW'((k * 97) % 1024);
      pix_in = p;
      #0.1;
      check(8, 32'(pix_req), 32'(h >= int'(cfg_hblank) && !vbit(v)));
      q.push_back(model(h, v, p));
      if (h == int'(cfg_line_len) - 1) begin
        h = 0;
        v = (v == int'(cfg_frame_lines) - 1) ? 0 : v + 1;
      end else h++;
      @(negedge clk);
    end
    @(negedge clk);
    check(2, 32'(q.size()), 0);
  endtask

  initial begin
    pix_in = '0;
    cfg_line_len = 20; cfg_hblank = 10; cfg_hsync_len = 3;
    cfg_frame_lines = 10; cfg_a1_start = 2; cfg_a1_end = 5; cfg_f2_line = 5;
    cfg_a2_start = 7; cfg_a2_end = 10; cfg_vsync_lines = 1;
    cfg_y_min = 10'h040; cfg_y_max = 10'h3AC; cfg_c_min = 10'h040; cfg_c_max = 10'h3C0;
    run_cfg(2, 0);
    cfg_line_len = 24; cfg_hblank = 12; cfg_hsync_len = 5;
    cfg_frame_lines = 8; cfg_a1_start = 1; cfg_a1_end = 4; cfg_f2_line = 4;
    cfg_a2_start = 5; cfg_a2_end = 8; cfg_vsync_lines = 2;
    cfg_y_min = 10'h100; cfg_y_max = 10'h300; cfg_c_min = 10'h080; cfg_c_max = 10'h380;
    run_cfg(2, 3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule